// File: doc/BRIEF.md
# Instruction Breakpoint Debug Control Unit

This block sits beside a small 16-bit CPU core and decides when the core must stop and hand control to debug software. It keeps one control byte and five 24-bit break address registers, all reached over a simple register bus. Each cycle in which the core presents a valid instruction fetch, the fetch address is compared against every break address whose enable bit is set. The block raises a one-cycle break request on the next clock edge when any enabled comparator matches. It also raises one when an external debug request arrives, or when single-step is on and a fetch completes.

The control byte also holds a sticky flag that records an external debug request until software clears it by writing 1. Bit 0 of the byte reports the core's current mode, and software cannot write it. While the core reports debug mode, no break request is produced. The flag still records external requests in that mode.

Top module: `brk_dbg_ctrl`

## Requirements
- R1: After synchronous reset, the control byte (bus address 0) reads 0x00 while the core is in user mode, all five break address registers read 0, and `brk_o` is low.
- R2: Break-enable bits are at control bit 7 (break 4), bit 6 (break 3), bit 5 (break 2), bit 3 (break 1) and bit 2 (break 0). Single-step is bit 1. All six read back exactly what was last written.
- R3: Break address register n (n = 0..4) sits at bus address n+1. It holds a 24-bit value that reads back as written. Unused bus addresses read 0.
- R4: With break n enabled, a cycle with `fetch_vld` high and `fetch_addr` equal to break address n makes `brk_o` high in the following cycle. It stays high for that one cycle only, unless another trigger follows.
- R5: A break whose enable bit is 0 never produces `brk_o`. A fetch address presented with `fetch_vld` low produces no break.
- R6: The request flag (control bit 4) becomes 1 in the cycle after `ext_dbg_req` is high. It stays 1 until a control write with bit 4 set clears it. A control write with bit 4 at 0 leaves it unchanged.
- R7: When `ext_dbg_req` is high in the same cycle as a control write that clears the flag, the flag ends up 1.
- R8: Control bit 0 reads the level of `core_dbg_mode` (1 for debug, 0 for user). Bus writes to bit 0 have no effect.
- R9: While `core_dbg_mode` is 1, `brk_o` stays low for every cause: address match, single-step and external request.
- R10: With single-step enabled and `core_dbg_mode` at 0, every cycle with `fetch_vld` high gives `brk_o` high in the next cycle, whatever the fetch address.
- R11: In user mode, a cycle with `ext_dbg_req` high gives `brk_o` high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register select: 0 is the control byte, 1..5 are break addresses 0..4 |
| bus_wdata | input | 24 | Write data; the control byte uses bits 7:0 |
| bus_we | input | 1 | Write strobe, taken on the rising clock edge |
| bus_rdata | output | 24 | Combinational read data for `bus_addr` |
| fetch_addr | input | 24 | Instruction fetch address |
| fetch_vld | input | 1 | Fetch address valid this cycle |
| ext_dbg_req | input | 1 | External debug request |
| core_dbg_mode | input | 1 | Core is in debug mode (1) or user mode (0) |
| brk_o | output | 1 | Registered break request to the core |

## Verification
Two functions can land in the same clock edge: the external request setting the flag, and a software write clearing it. The bench provokes this by raising `ext_dbg_req` in the very cycle that a control write with bit 4 set is presented. It then reads the control byte and expects the flag at 1. A later write alone must clear the flag, which shows the clear path itself still works.

// File: rtl/dbgc_pkg.sv
package dbgc_pkg;

    localparam int BRK_ADDR_W = 24;
    localparam int NUM_BRK    = 5;
    localparam int SEL_W      = 3;

    localparam logic [SEL_W-1:0] SEL_CTRL = 3'd0;

    // Control byte, MSB first; bit positions follow the software-visible layout.
    typedef struct packed {
        logic brk4_en;
        logic brk3_en;
        logic brk2_en;
        logic req_flag;
        logic brk1_en;
        logic brk0_en;
        logic step_en;
        logic dbg_mode;
    } ctrl_t;

    localparam int REQ_BIT = 4;

    function automatic logic [NUM_BRK-1:0] enables_of(input ctrl_t c);
        return {c.brk4_en, c.brk3_en, c.brk2_en, c.brk1_en, c.brk0_en};
    endfunction

    function automatic logic [SEL_W-1:0] brk_sel(input int idx);
        return SEL_W'(idx + 1);
    endfunction

endpackage

// File: rtl/dbgc_regs.sv
module dbgc_regs
    import dbgc_pkg::*;
#(
    parameter int ADDR_W = BRK_ADDR_W,
    parameter int NBRK   = NUM_BRK
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [SEL_W-1:0]             bus_addr,
    input  logic [ADDR_W-1:0]            bus_wdata,
    input  logic                         bus_we,
    output logic [ADDR_W-1:0]            bus_rdata,
    input  logic                         ext_dbg_req,
    input  logic                         core_dbg_mode,
    output logic [NBRK-1:0]              brk_en,
    output logic                         step_en,
    output logic [NBRK-1:0][ADDR_W-1:0]  brk_addr
);

    ctrl_t ctrl_q;
    ctrl_t wr_ctrl;
    ctrl_t rd_ctrl;
    logic  ctrl_wr;
    logic  flag_clr;

    assign wr_ctrl  = ctrl_t'(bus_wdata[7:0]);
    assign ctrl_wr  = bus_we && (bus_addr == SEL_CTRL);
    assign flag_clr = ctrl_wr && wr_ctrl.req_flag;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            if (ctrl_wr) begin
                ctrl_q.brk4_en <= wr_ctrl.brk4_en;
                ctrl_q.brk3_en <= wr_ctrl.brk3_en;
                ctrl_q.brk2_en <= wr_ctrl.brk2_en;
                ctrl_q.brk1_en <= wr_ctrl.brk1_en;
                ctrl_q.brk0_en <= wr_ctrl.brk0_en;
                ctrl_q.step_en <= wr_ctrl.step_en;
            end
            // a new request outranks a clear in the same cycle
            ctrl_q.req_flag <= ext_dbg_req | (ctrl_q.req_flag & ~flag_clr);
            ctrl_q.dbg_mode <= 1'b0;
        end
    end

    for (genvar g = 0; g < NBRK; g++) begin : g_brk_reg
        always_ff @(posedge clk) begin
            if (rst)
                brk_addr[g] <= '0;
            else if (bus_we && (bus_addr == brk_sel(g)))
                brk_addr[g] <= bus_wdata;
        end
    end

    always_comb begin
        rd_ctrl          = ctrl_q;
        rd_ctrl.dbg_mode = core_dbg_mode;
        bus_rdata        = '0;
        if (bus_addr == SEL_CTRL)
            bus_rdata[7:0] = rd_ctrl;
        for (int i = 0; i < NBRK; i++)
            if (bus_addr == brk_sel(i))
                bus_rdata = brk_addr[i];
    end

    assign brk_en  = enables_of(ctrl_q);
    assign step_en = ctrl_q.step_en;

    assert_flag_set_R7: assert property (@(posedge clk) disable iff (rst)
        ext_dbg_req |=> ctrl_q.req_flag);

    assert_flag_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.req_flag && !(bus_we && bus_addr == SEL_CTRL && bus_wdata[REQ_BIT]))
        |=> ctrl_q.req_flag);

endmodule

// File: rtl/dbgc_cmp.sv
module dbgc_cmp
    import dbgc_pkg::*;
#(
    parameter int ADDR_W = BRK_ADDR_W,
    parameter int NBRK   = NUM_BRK
) (
    input  logic [ADDR_W-1:0]            fetch_addr,
    input  logic                         cmp_on,
    input  logic [NBRK-1:0]              brk_en,
    input  logic [NBRK-1:0][ADDR_W-1:0]  brk_addr,
    output logic [NBRK-1:0]              hit
);

    for (genvar g = 0; g < NBRK; g++) begin : g_cmp
        assign hit[g] = cmp_on && brk_en[g] && (fetch_addr == brk_addr[g]);
    end

endmodule

// File: rtl/brk_dbg_ctrl.sv
module brk_dbg_ctrl
    import dbgc_pkg::*;
#(
    parameter int ADDR_W = BRK_ADDR_W,
    parameter int NBRK   = NUM_BRK
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  bus_addr,
    input  logic [ADDR_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [ADDR_W-1:0] bus_rdata,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_vld,
    input  logic              ext_dbg_req,
    input  logic              core_dbg_mode,
    output logic              brk_o
);

    logic [NBRK-1:0]             brk_en;
    logic [NBRK-1:0][ADDR_W-1:0] brk_addr;
    logic [NBRK-1:0]             hit;
    logic                        step_en;
    logic                        user_fetch;
    logic                        brk_d;
    logic                        brk_q;

    dbgc_regs #(.ADDR_W(ADDR_W), .NBRK(NBRK)) u_regs (
        .clk           (clk),
        .rst           (rst),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_we        (bus_we),
        .bus_rdata     (bus_rdata),
        .ext_dbg_req   (ext_dbg_req),
        .core_dbg_mode (core_dbg_mode),
        .brk_en        (brk_en),
        .step_en       (step_en),
        .brk_addr      (brk_addr)
    );

    assign user_fetch = fetch_vld && !core_dbg_mode;

    dbgc_cmp #(.ADDR_W(ADDR_W), .NBRK(NBRK)) u_cmp (
        .fetch_addr (fetch_addr),
        .cmp_on     (user_fetch),
        .brk_en     (brk_en),
        .brk_addr   (brk_addr),
        .hit        (hit)
    );

    assign brk_d = !core_dbg_mode && (ext_dbg_req || (fetch_vld && step_en) || (|hit));

    always_ff @(posedge clk) begin
        if (rst) brk_q <= 1'b0;
        else     brk_q <= brk_d;
    end

    assign brk_o = brk_q;

    always_comb begin
        assert_cmp_gated_R5: assert ((hit & ~brk_en) == '0);
    end

    assert_brk_cause_R4: assert property (@(posedge clk) disable iff (rst)
        brk_q |-> $past(fetch_vld || ext_dbg_req));

    assert_dbg_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        core_dbg_mode |=> !brk_q);

    assert_step_R10: assert property (@(posedge clk) disable iff (rst)
        (step_en && fetch_vld && !core_dbg_mode) |=> brk_q);

    assert_ext_brk_R11: assert property (@(posedge clk) disable iff (rst)
        (ext_dbg_req && !core_dbg_mode) |=> brk_q);

endmodule

// File: tb/test_brk_dbg_ctrl.sv
module test_brk_dbg_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic [23:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [23:0] bus_rdata;
    logic [23:0] fetch_addr = '0;
    logic        fetch_vld = 1'b0;
    logic        ext_dbg_req = 1'b0;
    logic        core_dbg_mode = 1'b0;
    logic        brk_o;

    int nchk = 0;
    int nfail = 0;

    always #10 clk = ~clk;

    brk_dbg_ctrl i_brk_dbg_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .fetch_addr(fetch_addr),
        .fetch_vld(fetch_vld), .ext_dbg_req(ext_dbg_req),
        .core_dbg_mode(core_dbg_mode), .brk_o(brk_o)
    );

    function automatic logic [23:0] pattern(input int i);
        return 24'h100000 + 24'(i) * 24'h011111;
    endfunction

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [23:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [23:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    // one valid fetch; returns brk_o in the next cycle and the cycle after
    task automatic fetch(input logic [23:0] a, input logic vld, output logic b1, output logic b2);
        @(negedge clk);
        fetch_addr = a; fetch_vld = vld;
        @(negedge clk);
        fetch_vld = 1'b0;
        b1 = brk_o;
        @(negedge clk);
        b2 = brk_o;
    endtask

    task automatic ext_pulse(output logic b);
        @(negedge clk);
        ext_dbg_req = 1'b1;
        @(negedge clk);
        ext_dbg_req = 1'b0;
        b = brk_o;
    endtask

    task automatic t_reset();
        logic [23:0] v;
        @(negedge clk);
        rd(3'd0, v); check("R1 ctrl", v, 24'h0);
        for (int i = 1; i <= 5; i++) begin
            rd(3'(i), v); check("R1 brk addr", v, 24'h0);
        end
        check("R1 brk_o", {23'd0, brk_o}, 24'h0);
    endtask

    task automatic t_ctrl_rw();
        logic [23:0] v;
        wr(3'd0, 24'h0000FF);
        rd(3'd0, v); check("R2/R8 write FF", v, 24'h0000EE);
        wr(3'd0, 24'h0000A4);
        rd(3'd0, v); check("R2 write A4", v, 24'h0000A4);
        wr(3'd0, 24'h00004A);
        rd(3'd0, v); check("R2 write 4A", v, 24'h00004A);
        wr(3'd0, 24'h0);
        rd(3'd0, v); check("R2 write 00", v, 24'h0);
    endtask

    task automatic t_addr_rw();
        logic [23:0] v;
        for (int i = 0; i < 5; i++) wr(3'(i + 1), pattern(i));
        for (int i = 0; i < 5; i++) begin
            rd(3'(i + 1), v); check("R3 brk addr", v, pattern(i));
        end
        wr(3'd6, 24'hFFFFFF);
        rd(3'd6, v); check("R3 unused addr", v, 24'h0);
    endtask

    task automatic t_match();
        logic b1, b2;
        wr(3'd0, 24'h00000C);
        fetch(pattern(0), 1'b1, b1, b2);
        check("R4 break0 hit", {23'd0, b1}, 24'h1);
        check("R4 one-cycle pulse", {23'd0, b2}, 24'h0);
        fetch(pattern(1), 1'b1, b1, b2);
        check("R4 break1 hit", {23'd0, b1}, 24'h1);
        fetch(pattern(4), 1'b1, b1, b2);
        check("R5 break4 disabled", {23'd0, b1}, 24'h0);
        fetch(pattern(0), 1'b0, b1, b2);
        check("R5 no fetch_vld", {23'd0, b1}, 24'h0);
        wr(3'd0, 24'h000080);
        fetch(pattern(4), 1'b1, b1, b2);
        check("R4 break4 hit", {23'd0, b1}, 24'h1);
        fetch(pattern(0), 1'b1, b1, b2);
        check("R5 break0 now disabled", {23'd0, b1}, 24'h0);
        wr(3'd0, 24'h0);
    endtask

    task automatic t_flag();
        logic [23:0] v;
        logic b;
        ext_pulse(b);
        check("R11 ext request brk", {23'd0, b}, 24'h1);
        repeat (3) @(negedge clk);
        rd(3'd0, v); check("R6 flag sticky", v, 24'h000010);
        wr(3'd0, 24'h0);
        rd(3'd0, v); check("R6 write 0 keeps flag", v, 24'h000010);
        wr(3'd0, 24'h000010);
        rd(3'd0, v); check("R6 write 1 clears", v, 24'h0);
    endtask

    task automatic t_collision();
        logic [23:0] v;
        @(negedge clk);
        ext_dbg_req = 1'b1;
        bus_addr = 3'd0; bus_wdata = 24'h000010; bus_we = 1'b1;
        @(negedge clk);
        ext_dbg_req = 1'b0; bus_we = 1'b0;
        rd(3'd0, v); check("R7 set beats clear", v, 24'h000010);
        wr(3'd0, 24'h000010);
        rd(3'd0, v); check("R7 later clear", v, 24'h0);
    endtask

    task automatic t_mode();
        logic [23:0] v;
        logic b1, b2, b;
        core_dbg_mode = 1'b1;
        wr(3'd0, 24'h00000E);
        rd(3'd0, v); check("R8 mode reads 1", v, 24'h00000F);
        fetch(pattern(0), 1'b1, b1, b2);
        check("R9 no hit in debug", {23'd0, b1}, 24'h0);
        ext_pulse(b);
        @(negedge clk);
        check("R9 no ext brk in debug", {23'd0, b || brk_o}, 24'h0);
        rd(3'd0, v); check("R9 flag still set", v, 24'h00001F);
        wr(3'd0, 24'h000010);
        core_dbg_mode = 1'b0;
        rd(3'd0, v); check("R8 mode reads 0", v, 24'h0);
    endtask

    task automatic t_step();
        logic b1, b2;
        wr(3'd0, 24'h000002);
        fetch(24'h000777, 1'b1, b1, b2);
        check("R10 step brk", {23'd0, b1}, 24'h1);
        @(negedge clk);
        fetch_addr = 24'h000100; fetch_vld = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            fetch_addr = fetch_addr + 24'd2;
            check("R10 back-to-back step", {23'd0, brk_o}, 24'h1);
        end
        fetch_vld = 1'b0;
        wr(3'd0, 24'h0);
        fetch(24'h000777, 1'b1, b1, b2);
        check("R10 step off", {23'd0, b1}, 24'h0);
    endtask

    initial begin
        #(20 * 200000);
        nfail++; nchk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ctrl_rw();
        t_addr_rw();
        t_match();
        t_flag();
        t_collision();
        t_mode();
        t_step();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule